// File: doc/BRIEF.md
# Wavefront Instruction Fetch Issuer

This block sits in front of the instruction path of a compute unit that runs several hardware thread-group slots. Each cycle it looks at the status of every slot that is not already waiting in line. A slot that is running, has a shallow instruction buffer with no branch in it, and has no fetch already in flight joins the tail of an ordered line of eligible slots. The slot at the head of that line is then picked, marked as having a fetch outstanding, and one fetch request is presented on a valid/ready request port.

The fetch address is formed from the slot's base address, its program counter and its current buffer occupancy, with 8-byte instruction words. The request length is a full cache line when the address is line-aligned. Otherwise it runs from the address up to the end of the line it falls in. The request port follows the usual valid/ready rules. Once `req_valid` is high, the address, length and slot stay unchanged until a cycle in which `req_ready` is also high. While a request waits, no new slot is picked. When the instruction data for a slot comes back, the surrounding logic pulses `fill_valid` with that slot number, which clears the slot's outstanding flag.

Top module: `fetch_issuer`

## Requirements
- R1: A slot enters the eligible line only if all of the following hold: `slot_running` is 1, its `slot_occ` is 4 or less, `slot_has_branch` is 0, and it has no fetch outstanding. An occupancy of 5 or more, a branch flag, or a running flag of 0 each keep the slot out of the line.
- R2: Slots that become eligible in the same cycle join the line in ascending slot order. Slots that become eligible in different cycles are served in the order they became eligible.
- R3: `req_valid` is 0 after reset. A new request is launched only when the line is non-empty, and at most one is launched per cycle. A slot whose inputs become eligible is presented on `req_valid` after the second rising clock edge.
- R4: A launched slot has a fetch outstanding. It is not queued or launched again until a `fill_valid` pulse carrying its number in `fill_slot` has been seen.
- R5: `req_addr` equals `slot_base + (slot_pc + slot_occ) * 8`, with all three values taken from the chosen slot in the cycle it is launched.
- R6: With line size L (a power of two, 64 by default), `req_len` equals L minus (`req_addr` mod L). The result is L for an aligned address and always ends the request exactly at a line boundary.
- R7: While `req_valid` is 1 and `req_ready` is 0, the request is held: `req_valid` stays 1 and `req_addr`, `req_len` and `req_slot` do not change, and no other slot is launched.
- R8: A slot that is already in the line stays there and is launched in its turn even if its status stops meeting the eligibility rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_running | input | NUM_SLOTS | Per-slot running flag |
| slot_occ | input | NUM_SLOTS*OCC_W | Per-slot instruction-buffer occupancy, slot i in bits [i*OCC_W +: OCC_W] |
| slot_has_branch | input | NUM_SLOTS | Per-slot flag: the buffer holds a branch |
| slot_pc | input | NUM_SLOTS*ADDR_W | Per-slot program counter in instruction words |
| slot_base | input | NUM_SLOTS*ADDR_W | Per-slot base byte address |
| fill_valid | input | 1 | Pulse: fetch data for `fill_slot` has returned |
| fill_slot | input | SLOT_W | Slot whose fetch completed |
| req_valid | output | 1 | Fetch request present |
| req_ready | input | 1 | Downstream accepts the request this cycle |
| req_addr | output | ADDR_W | Fetch byte address |
| req_len | output | LINE_LG+1 | Fetch length in bytes |
| req_slot | output | SLOT_W | Slot that owns the request |

## Verification
An eligible slot is entered into the line on the first rising edge and launched on the second. The bench drives each stimulus on a falling edge, waits exactly two rising edges, and samples `req_*` on the following falling edge. Each later request in a back-to-back burst is sampled one cycle after the one before it. A returned fill takes one edge to clear the outstanding flag, and the slot then needs two more edges before it is requested again, so the bench waits one cycle and then two before it checks for the repeat request. Held requests under back-pressure are sampled on several consecutive falling edges while `req_ready` is 0, to confirm that the payload stays stable.

// File: rtl/fetch_issuer_pkg.sv
package fetch_issuer_pkg;
  // largest buffer occupancy at which a slot may still fetch
  localparam int OCC_LIMIT = 4;
  // log2 of the instruction word size in bytes (8-byte words)
  localparam int INST_LG   = 3;
endpackage

// File: rtl/fetch_elig.sv
module fetch_elig
  import fetch_issuer_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int OCC_W     = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] running,
  input  logic [OCC_W-1:0]     occ [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0] has_branch,
  input  logic [NUM_SLOTS-1:0] queued,
  input  logic [NUM_SLOTS-1:0] pending,
  output logic [NUM_SLOTS-1:0] push_mask,
  output logic [SLOT_W-1:0]    push_rank [NUM_SLOTS],
  output logic [SLOT_W:0]      push_cnt
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_rule
    assign push_mask[g] = running[g] && (occ[g] <= OCC_W'(OCC_LIMIT)) &&
                          !has_branch[g] && !pending[g] && !queued[g];
  end

  // position of each new entry among this cycle's pushes, low slot first
  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      push_rank[i] = SLOT_W'(cnt);
      if (push_mask[i]) cnt = cnt + 1;
    end
    push_cnt = (SLOT_W+1)'(cnt);
  end

endmodule

// File: rtl/fetch_queue.sv
module fetch_queue #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] push_mask,
  input  logic [SLOT_W-1:0]    push_rank [NUM_SLOTS],
  input  logic [SLOT_W:0]      push_cnt,
  input  logic                 pop,
  output logic                 not_empty,
  output logic [SLOT_W-1:0]    head_id
);

  localparam logic [SLOT_W:0] DEPTH = (SLOT_W+1)'(NUM_SLOTS);

  logic [SLOT_W-1:0] ids [NUM_SLOTS];
  logic [SLOT_W-1:0] head_q, tail_q;
  logic [SLOT_W:0]   count_q;
  logic [SLOT_W-1:0] wpos [NUM_SLOTS];
  logic [SLOT_W:0]   psum [NUM_SLOTS];
  logic [SLOT_W:0]   tail_sum, head_sum;

  assign not_empty = (count_q != '0);
  assign head_id   = ids[head_q];

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      psum[i] = {1'b0, tail_q} + {1'b0, push_rank[i]};
      if (psum[i] >= DEPTH) psum[i] = psum[i] - DEPTH;
      wpos[i] = psum[i][SLOT_W-1:0];
    end
    tail_sum = {1'b0, tail_q} + push_cnt;
    if (tail_sum >= DEPTH) tail_sum = tail_sum - DEPTH;
    head_sum = {1'b0, head_q} + (SLOT_W+1)'(pop);
    if (head_sum >= DEPTH) head_sum = head_sum - DEPTH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) ids[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (push_mask[i]) ids[wpos[i]] <= SLOT_W'(i);
      head_q  <= head_sum[SLOT_W-1:0];
      tail_q  <= tail_sum[SLOT_W-1:0];
      count_q <= count_q + push_cnt - (SLOT_W+1)'(pop);
    end
  end

endmodule

// File: rtl/fetch_addr.sv
module fetch_addr
  import fetch_issuer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OCC_W      = 4,
  parameter int LINE_BYTES = 64,
  localparam int LINE_LG   = $clog2(LINE_BYTES),
  localparam int LEN_W     = LINE_LG + 1
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OCC_W-1:0]  occ,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len
);

  logic [ADDR_W-1:0]  word_idx;
  logic [LINE_LG-1:0] line_off;

  assign word_idx = pc + ADDR_W'(occ);
  assign addr     = base + (word_idx << INST_LG);
  assign line_off = addr[LINE_LG-1:0];
  // bytes left in the line; a full line when the offset is zero
  assign len      = LEN_W'(LINE_BYTES) - {1'b0, line_off};

endmodule

// File: rtl/fetch_issuer.sv
module fetch_issuer
  import fetch_issuer_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int ADDR_W     = 32,
  parameter int OCC_W      = 4,
  parameter int LINE_BYTES = 64,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int LINE_LG   = $clog2(LINE_BYTES),
  localparam int LEN_W     = LINE_LG + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SLOTS-1:0]          slot_running,
  input  logic [NUM_SLOTS*OCC_W-1:0]    slot_occ,
  input  logic [NUM_SLOTS-1:0]          slot_has_branch,
  input  logic [NUM_SLOTS*ADDR_W-1:0]   slot_pc,
  input  logic [NUM_SLOTS*ADDR_W-1:0]   slot_base,
  input  logic                          fill_valid,
  input  logic [SLOT_W-1:0]             fill_slot,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [ADDR_W-1:0]             req_addr,
  output logic [LEN_W-1:0]              req_len,
  output logic [SLOT_W-1:0]             req_slot
);

  logic [ADDR_W-1:0] pc_a   [NUM_SLOTS];
  logic [ADDR_W-1:0] base_a [NUM_SLOTS];
  logic [OCC_W-1:0]  occ_a  [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
    assign pc_a[g]   = slot_pc[g*ADDR_W +: ADDR_W];
    assign base_a[g] = slot_base[g*ADDR_W +: ADDR_W];
    assign occ_a[g]  = slot_occ[g*OCC_W +: OCC_W];
  end

  logic [NUM_SLOTS-1:0] queued_q, pending_q;
  logic [NUM_SLOTS-1:0] push_mask;
  logic [SLOT_W-1:0]    push_rank [NUM_SLOTS];
  logic [SLOT_W:0]      push_cnt;
  logic                 q_not_empty, launch;
  logic [SLOT_W-1:0]    head_id;
  logic [ADDR_W-1:0]    calc_addr;
  logic [LEN_W-1:0]     calc_len;
  logic [NUM_SLOTS-1:0] head_oh, fill_oh;

  fetch_elig #(.NUM_SLOTS(NUM_SLOTS), .OCC_W(OCC_W)) u_elig (
    .running    (slot_running),
    .occ        (occ_a),
    .has_branch (slot_has_branch),
    .queued     (queued_q),
    .pending    (pending_q),
    .push_mask  (push_mask),
    .push_rank  (push_rank),
    .push_cnt   (push_cnt)
  );

  // a new request may go out when the port is free or is emptying now
  assign launch = q_not_empty && (!req_valid || req_ready);

  fetch_queue #(.NUM_SLOTS(NUM_SLOTS)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_mask (push_mask),
    .push_rank (push_rank),
    .push_cnt  (push_cnt),
    .pop       (launch),
    .not_empty (q_not_empty),
    .head_id   (head_id)
  );

  fetch_addr #(
    .ADDR_W(ADDR_W), .OCC_W(OCC_W), .LINE_BYTES(LINE_BYTES)
  ) u_addr (
    .pc   (pc_a[head_id]),
    .occ  (occ_a[head_id]),
    .base (base_a[head_id]),
    .addr (calc_addr),
    .len  (calc_len)
  );

  assign head_oh = launch     ? (NUM_SLOTS'(1) << head_id)   : '0;
  assign fill_oh = fill_valid ? (NUM_SLOTS'(1) << fill_slot) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      queued_q  <= '0;
      pending_q <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_len   <= '0;
      req_slot  <= '0;
    end else begin
      queued_q  <= (queued_q | push_mask) & ~head_oh;
      pending_q <= (pending_q & ~fill_oh) | head_oh;
      if (launch) begin
        req_valid <= 1'b1;
        req_addr  <= calc_addr;
        req_len   <= calc_len;
        req_slot  <= head_id;
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fetch_issuer_chk.sv
module fetch_issuer_chk #(
  parameter int NUM_SLOTS  = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int LINE_LG   = $clog2(LINE_BYTES),
  localparam int LEN_W     = LINE_LG + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [SLOT_W-1:0] req_slot,
  input logic              fill_valid,
  input logic [SLOT_W-1:0] fill_slot
);

  logic                 stall_q;
  logic [NUM_SLOTS-1:0] issued_q;
  logic                 new_req;
  logic [LEN_W:0]       end_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q  <= 1'b0;
      issued_q <= '0;
    end else begin
      stall_q <= req_valid && !req_ready;
      if (req_valid && req_ready) issued_q[req_slot] <= 1'b1;
      if (fill_valid) issued_q[fill_slot] <= 1'b0;
    end
  end

  assign new_req = req_valid && !stall_q;
  assign end_off = {2'b00, req_addr[LINE_LG-1:0]} + {1'b0, req_len};

  // R3: nothing is requested in the first cycle after reset
  p_idle_after_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !req_valid);

  // R4: no second request for a slot whose fetch has not come back
  p_no_refetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    new_req |-> !issued_q[req_slot]);

  // R6: every request stops exactly at a line boundary
  p_line_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (end_off == (LEN_W+1)'(LINE_BYTES)));

  // R7: a refused request is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_slot)));

endmodule

bind fetch_issuer fetch_issuer_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .req_slot   (req_slot),
  .fill_valid (fill_valid),
  .fill_slot  (fill_slot)
);

// File: tb/sim_fetch_issuer.sv
`timescale 1ns/1ps
module sim_fetch_issuer;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int OW = 4;
  localparam int SW = 3;
  localparam int LW = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    slot_running = '0;
  logic [N*OW-1:0] slot_occ = '0;
  logic [N-1:0]    slot_has_branch = '0;
  logic [N*AW-1:0] slot_pc = '0;
  logic [N*AW-1:0] slot_base = '0;
  logic            fill_valid = 1'b0;
  logic [SW-1:0]   fill_slot = '0;
  logic            req_valid;
  logic            req_ready = 1'b1;
  logic [AW-1:0]   req_addr;
  logic [LW-1:0]   req_len;
  logic [SW-1:0]   req_slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fetch_issuer u0 (
    .clk(clk), .rst_n(rst_n), .slot_running(slot_running), .slot_occ(slot_occ),
    .slot_has_branch(slot_has_branch), .slot_pc(slot_pc), .slot_base(slot_base),
    .fill_valid(fill_valid), .fill_slot(fill_slot), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len), .req_slot(req_slot)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_slot(input int s, input bit run, input int occ, input bit br,
                          input int pc, input int base);
    slot_running[s]          = run;
    slot_occ[s*OW +: OW]     = OW'(occ);
    slot_has_branch[s]       = br;
    slot_pc[s*AW +: AW]      = AW'(pc);
    slot_base[s*AW +: AW]    = AW'(base);
  endtask

  task automatic expect_req(input string tag, input int s, input longint a, input int l);
    chk(req_valid == 1'b1, {tag, " valid"}, req_valid, 1);
    chk(req_slot == SW'(s), {tag, " slot"}, req_slot, s);
    if (a >= 0) chk(req_addr == AW'(a), {tag, " addr"}, req_addr, a);
    if (l >= 0) chk(req_len == LW'(l), {tag, " len"}, req_len, l);
  endtask

  task automatic cleanup();
    slot_running = '0;
    req_ready = 1'b1;
    step(6);
    for (int s = 0; s < N; s++) begin
      fill_valid = 1'b1;
      fill_slot = SW'(s);
      step(1);
    end
    fill_valid = 1'b0;
    step(2);
  endtask

  task automatic t_reset();
    chk(req_valid == 1'b0, "R3 reset idle", req_valid, 0);
  endtask

  task automatic t_basic();
    set_slot(3, 1, 2, 0, 10, 'h1000);
    step(2);
    expect_req("R5 R6 basic", 3, 'h1060, 32);
    step(1);
    chk(req_valid == 1'b0, "R3 single launch", req_valid, 0);
    step(3);
    chk(req_valid == 1'b0, "R4 no refetch while pending", req_valid, 0);
    fill_valid = 1'b1;
    fill_slot = 3'd3;
    step(1);
    fill_valid = 1'b0;
    step(2);
    expect_req("R4 refetch after fill", 3, 'h1060, 32);
    cleanup();
  endtask

  task automatic t_align();
    set_slot(2, 1, 0, 0, 7, 'h40);
    set_slot(6, 1, 1, 0, 7, 'h2000);
    step(2);
    expect_req("R6 short tail", 2, 'h78, 8);
    step(1);
    expect_req("R6 aligned full line", 6, 'h2040, 64);
    cleanup();
  endtask

  task automatic t_elig();
    set_slot(4, 1, 5, 0, 0, 'h3000);
    step(4);
    chk(req_valid == 1'b0, "R1 occupancy 5 blocked", req_valid, 0);
    set_slot(4, 1, 2, 1, 0, 'h3000);
    step(4);
    chk(req_valid == 1'b0, "R1 branch blocked", req_valid, 0);
    set_slot(4, 0, 2, 0, 0, 'h3000);
    step(4);
    chk(req_valid == 1'b0, "R1 not running blocked", req_valid, 0);
    set_slot(4, 1, 4, 0, 0, 'h3000);
    step(2);
    expect_req("R1 occupancy 4 allowed", 4, 'h3020, 32);
    cleanup();
  endtask

  task automatic t_same_cycle();
    set_slot(5, 1, 0, 0, 0, 'h500);
    set_slot(1, 1, 0, 0, 0, 'h100);
    set_slot(6, 1, 0, 0, 0, 'h600);
    step(2);
    expect_req("R2 first ascending", 1, 'h100, -1);
    step(1);
    expect_req("R2 second ascending", 5, 'h500, -1);
    step(1);
    expect_req("R2 third ascending", 6, 'h600, -1);
    step(1);
    chk(req_valid == 1'b0, "R3 queue drained", req_valid, 0);
    cleanup();
  endtask

  task automatic t_hold();
    logic [AW-1:0] held;
    req_ready = 1'b0;
    set_slot(7, 1, 1, 0, 3, 'h7000);
    step(2);
    expect_req("R7 held first", 7, 'h7020, 32);
    held = req_addr;
    set_slot(0, 1, 0, 0, 0, 'h80);
    step(1);
    set_slot(2, 1, 0, 0, 1, 'h200);
    slot_running[0] = 1'b0;
    step(1);
    expect_req("R7 stable while stalled", 7, held, 32);
    step(2);
    expect_req("R7 still stable", 7, held, 32);
    req_ready = 1'b1;
    step(1);
    expect_req("R8 queued slot served after losing eligibility", 0, 'h80, 64);
    step(1);
    expect_req("R2 arrival order", 2, 'h208, 56);
    cleanup();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step(1);
    chk(req_valid == 1'b0, "R3 idle after reset", req_valid, 0);
    t_basic();
    t_align();
    t_elig();
    t_same_cycle();
    t_hold();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule